// File: doc/BRIEF.md
# Power-Cut Wake-Up Sequencer

This block takes a chip into and out of a deep power-cut state. Software arms it by writing a control register that holds an enable bit and a 2-bit warm-up select. An entry request made while the block is armed removes power from the gated domains. It also puts the pads into isolation: outputs are held at high impedance at their last state and input gates are switched off. A hot reset is held on the gated logic for as long as the power is off.

In the power-cut state the block watches ten wake lines, each with a fixed edge. These are a real-time-clock interrupt, eight external interrupts and one key line formed as the OR of nine key inputs. An accepted wake edge turns the power-enable output back on. The block then counts a warm-up interval picked by the warm-up select. When the interval ends it releases the hot reset and lifts the pad isolation. The boot-source override stays asserted so that the processor starts from internal ROM, and it drops only when software clears the enable bit.

The enable bit is sticky. To arm the block again, software must clear the bit, let a guard interval pass, and set the bit once more. A set attempted during the guard interval is refused and flagged.

Top module: `pcut_wake_ctrl`

## Requirements
- R1: After reset: cfg_en=0, cfg_wsel=00, cfg_rejected=0, pwr_en=1, hot_rst_n=1, pad_iso=0, in_gate_on=1, boot_rom_force=0.
- R2: A write with cfg_en_wr=1, made while cfg_en=0 and no guard interval is running, sets cfg_en=1, loads cfg_wsel from cfg_wsel_wr, clears cfg_rejected and arms the block. All of this is visible the cycle after the write.
- R3: Only a write with cfg_en_wr=0 lowers cfg_en, and that write also forces cfg_wsel to 00. A write with cfg_en_wr=1 while cfg_en=1 changes neither cfg_en nor cfg_wsel.
- R4: Every clearing write starts a guard of GUARD_CYC cycles. The guard covers the GUARD_CYC writes that immediately follow the clear. A set write that falls inside the guard is ignored (cfg_en stays 0) and sets cfg_rejected=1. The first set write after the guard is accepted.
- R5: An enter_req while armed moves the block into power-cut in the next cycle, giving pwr_en=0, hot_rst_n=0, pad_iso=1, in_gate_on=0 and boot_rom_force=1. Entry consumes the arming.
- R6: In power-cut, a wake is a rising edge on wake_rtc, on wake_ext[6:0] or on the OR of wake_key[8:0], or a falling edge on wake_ext[7]. An edge in the opposite direction has no effect. Edges seen outside power-cut have no effect.
- R7: The cycle after a wake edge, pwr_en is 1 and hot_rst_n is still 0.
- R8: hot_rst_n rises exactly 2^WEXPn cycles after pwr_en rises, where n is the cfg_wsel value when the block was entered (00→WEXP0, 01→WEXP1, 10→WEXP2, 11→WEXP3). pad_iso falls to 0 and in_gate_on rises to 1 in that same cycle.
- R9: boot_rom_force stays 1 from entry, through the exit, until cfg_en is cleared while the block is running.
- R10: After an exit, enter_req is ignored until cfg_en has been cleared and set again. A set write made while cfg_en=1 does not re-arm the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_en_wr | input | 1 | Write data: enable bit |
| cfg_wsel_wr | input | 2 | Write data: warm-up select |
| enter_req | input | 1 | Request to enter power-cut |
| wake_rtc | input | 1 | Real-time-clock interrupt (rising edge) |
| wake_ext | input | 8 | External interrupts; [7] falling edge, others rising |
| wake_key | input | 9 | Key inputs, ORed, rising edge |
| cfg_en | output | 1 | Enable bit |
| cfg_wsel | output | 2 | Warm-up select |
| cfg_rejected | output | 1 | A set write was refused during the guard |
| pwr_en | output | 1 | Power enable for the gated domains |
| hot_rst_n | output | 1 | Hot reset to the gated logic, active low |
| pad_iso | output | 1 | Pad outputs held at high impedance at their last state |
| in_gate_on | output | 1 | Pad input gates enabled |
| boot_rom_force | output | 1 | Override that forces boot from internal ROM |

## Verification
The hardest case to reach is an edge in the wrong direction on a wake line during power-cut. Every wake line idles at its inactive level, so no edge of either kind can happen until the line has first been moved. For each of the ten lines and each warm-up select, the bench therefore parks the line at its active level before entry. Inside power-cut it drives the line to the opposite level, which is a wrong-direction edge that must leave the power off. It then returns the line to the active level, which is the real wake, and measures the warm-up length from there. The guard boundary is covered by timing a set write to land on the last guarded cycle and the next write to land on the first free cycle.

// File: rtl/pcut_pkg.sv
// Shared types and helpers for the power-cut wake-up sequencer.
package pcut_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_CUT  = 2'd1,
        ST_WARM = 2'd2
    } pcut_state_e;

    localparam int NUM_WAKE = 10;   // rtc, ext[7:0], key OR
endpackage

// File: rtl/pcut_cfg_reg.sv
// Control register: sticky enable bit, warm-up select, re-arm guard and
// refused-write flag. Assumes write strobes are synchronous to clk.
module pcut_cfg_reg #(
    parameter int GUARD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       wd_en,
    input  logic [1:0] wd_wsel,
    input  logic       enter_ack,
    output logic       en,
    output logic [1:0] wsel,
    output logic       rejected,
    output logic       armed
);
    localparam int GW = $clog2(GUARD_CYC + 1);
    localparam logic [GW-1:0] GLOAD = GW'(GUARD_CYC);

    logic [GW-1:0] guard_cnt;
    logic          guard_busy;
    logic          set_ok;
    logic          set_bad;
    logic          clr_wr;

    assign guard_busy = (guard_cnt != '0);
    assign clr_wr     = we && !wd_en;
    assign set_ok     = we && wd_en && !en && !guard_busy;
    assign set_bad    = we && wd_en && !en && guard_busy;

    // Enable bit and select: set only when free, cleared only explicitly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            wsel <= 2'b00;
        end else if (clr_wr) begin
            en   <= 1'b0;
            wsel <= 2'b00;
        end else if (set_ok) begin
            en   <= 1'b1;
            wsel <= wd_wsel;
        end
    end

    // Guard counter restarted by every clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)          guard_cnt <= '0;
        else if (clr_wr)     guard_cnt <= GLOAD;
        else if (guard_busy) guard_cnt <= guard_cnt - 1'b1;
    end

    // Refused-write flag: raised on a guarded set, dropped on a good set.
    always_ff @(posedge clk) begin
        if (!rst_n)       rejected <= 1'b0;
        else if (set_bad) rejected <= 1'b1;
        else if (set_ok)  rejected <= 1'b0;
    end

    // Arming: given by an accepted set, consumed by entry or a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  armed <= 1'b0;
        else if (clr_wr || enter_ack) armed <= 1'b0;
        else if (set_ok)             armed <= 1'b1;
    end

    // R3: enable stays high unless a clearing write arrives
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr_wr) |=> en);
    // R3: enable falling always leaves select at 00
    p_wsel_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> (wsel == 2'b00));
    // R4: a set inside the guard is refused and flagged
    p_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wd_en && !en && guard_busy) |=> (!en && rejected));
endmodule

// File: rtl/pcut_wake_det.sv
// Edge detector for the wake lines. Each line has a fixed polarity given by
// FALL_MASK (1 = falling edge). Inputs are assumed already synchronous to clk.
module pcut_wake_det #(
    parameter int                N         = 10,
    parameter logic [N-1:0]      FALL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic         listen,
    output logic         hit
);
    logic [N-1:0] prev;
    logic [N-1:0] edge_v;

    // Track every line in all states so no stale edge appears on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= lines;
        else        prev <= lines;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        if (FALL_MASK[i]) begin : g_fall
            assign edge_v[i] = prev[i] && !lines[i];
        end else begin : g_rise
            assign edge_v[i] = !prev[i] && lines[i];
        end
    end

    assign hit = listen && (|edge_v);
endmodule

// File: rtl/pcut_seq.sv
// Power-cut sequencer: entry, wake acceptance, warm-up count and release.
// Warm-up length is 2^WEXPn slow-clock cycles, n latched at entry.
module pcut_seq
    import pcut_pkg::*;
#(
    parameter int WEXP0 = 10,
    parameter int WEXP1 = 12,
    parameter int WEXP2 = 14,
    parameter int WEXP3 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_req,
    input  logic       armed,
    input  logic       en,
    input  logic [1:0] wsel,
    input  logic       wake_hit,
    output logic       listen,
    output logic       enter_ack,
    output logic       pwr_en,
    output logic       hot_rst_n,
    output logic       pad_iso,
    output logic       in_gate_on,
    output logic       boot_rom_force
);
    localparam int MAXA = (WEXP0 > WEXP1) ? WEXP0 : WEXP1;
    localparam int MAXB = (WEXP2 > WEXP3) ? WEXP2 : WEXP3;
    localparam int CW   = ((MAXA > MAXB) ? MAXA : MAXB) + 1;

    pcut_state_e   state;
    logic [1:0]    sel_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Final count value for the latched select.
    always_comb begin
        unique case (sel_q)
            2'd0:    last = CW'((64'd1 << WEXP0) - 1);
            2'd1:    last = CW'((64'd1 << WEXP1) - 1);
            2'd2:    last = CW'((64'd1 << WEXP2) - 1);
            default: last = CW'((64'd1 << WEXP3) - 1);
        endcase
    end

    assign enter_ack = (state == ST_RUN) && enter_req && armed;
    assign listen    = (state == ST_CUT);

    // State machine with warm-up counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            sel_q <= 2'b00;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_RUN: if (enter_ack) begin
                    state <= ST_CUT;
                    sel_q <= wsel;
                end
                ST_CUT: if (wake_hit) begin
                    state <= ST_WARM;
                    cnt   <= '0;
                end
                ST_WARM: if (cnt == last) state <= ST_RUN;
                         else             cnt   <= cnt + 1'b1;
                default: state <= ST_RUN;
            endcase
        end
    end

    // Boot override: set at entry, dropped once running with enable cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)                          boot_rom_force <= 1'b0;
        else if (enter_ack)                  boot_rom_force <= 1'b1;
        else if (state == ST_RUN && !en)     boot_rom_force <= 1'b0;
    end

    assign pwr_en     = (state != ST_CUT);
    assign hot_rst_n  = (state == ST_RUN);
    assign pad_iso    = (state != ST_RUN);
    assign in_gate_on = (state == ST_RUN);

    // R5: power off implies isolation and hot reset
    p_cut_iso_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (pad_iso && !in_gate_on && !hot_rst_n));
    // R7: an accepted wake powers up while reset stays held
    p_wake_pwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (listen && wake_hit) |=> (pwr_en && !hot_rst_n));
    // R8: reset only released after power was already on
    p_rel_after_pwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hot_rst_n) |-> $past(pwr_en));
    // R8: warm-up counter never passes its final value
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WARM) |-> (cnt <= last));
    // R9: boot override present whenever hot reset is held
    p_boot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hot_rst_n |-> boot_rom_force);
endmodule

// File: rtl/pcut_wake_ctrl.sv
// Top of the power-cut wake-up sequencer. Wake line order into the detector:
// [0]=rtc, [8:1]=ext[7:0], [9]=OR of key inputs; ext[7] is falling-edge.
module pcut_wake_ctrl #(
    parameter int GUARD_CYC = 2,
    parameter int WEXP0     = 10,
    parameter int WEXP1     = 12,
    parameter int WEXP2     = 14,
    parameter int WEXP3     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_en_wr,
    input  logic [1:0] cfg_wsel_wr,
    input  logic       enter_req,
    input  logic       wake_rtc,
    input  logic [7:0] wake_ext,
    input  logic [8:0] wake_key,
    output logic       cfg_en,
    output logic [1:0] cfg_wsel,
    output logic       cfg_rejected,
    output logic       pwr_en,
    output logic       hot_rst_n,
    output logic       pad_iso,
    output logic       in_gate_on,
    output logic       boot_rom_force
);
    import pcut_pkg::*;

    localparam logic [NUM_WAKE-1:0] FALL_MASK = NUM_WAKE'(1) << 8;

    logic                armed;
    logic                enter_ack;
    logic                listen;
    logic                wake_hit;
    logic [NUM_WAKE-1:0] lines;

    assign lines = {(|wake_key), wake_ext, wake_rtc};

    pcut_cfg_reg #(.GUARD_CYC(GUARD_CYC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wd_en(cfg_en_wr),
        .wd_wsel(cfg_wsel_wr), .enter_ack(enter_ack), .en(cfg_en),
        .wsel(cfg_wsel), .rejected(cfg_rejected), .armed(armed)
    );

    pcut_wake_det #(.N(NUM_WAKE), .FALL_MASK(FALL_MASK)) u_det (
        .clk(clk), .rst_n(rst_n), .lines(lines), .listen(listen),
        .hit(wake_hit)
    );

    pcut_seq #(.WEXP0(WEXP0), .WEXP1(WEXP1), .WEXP2(WEXP2), .WEXP3(WEXP3)) u_seq (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .armed(armed),
        .en(cfg_en), .wsel(cfg_wsel), .wake_hit(wake_hit), .listen(listen),
        .enter_ack(enter_ack), .pwr_en(pwr_en), .hot_rst_n(hot_rst_n),
        .pad_iso(pad_iso), .in_gate_on(in_gate_on),
        .boot_rom_force(boot_rom_force)
    );
endmodule

// File: tb/tb_pcut_wake_ctrl.sv
module tb_pcut_wake_ctrl;
    localparam int G = 3;
    localparam int E0 = 2, E1 = 3, E2 = 4, E3 = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_en_wr = 1'b0;
    logic [1:0] cfg_wsel_wr = 2'b00;
    logic enter_req = 1'b0;
    logic wake_rtc = 1'b0;
    logic [7:0] wake_ext = 8'h80;
    logic [8:0] wake_key = '0;
    logic cfg_en, cfg_rejected, pwr_en, hot_rst_n, pad_iso, in_gate_on, boot_rom_force;
    logic [1:0] cfg_wsel;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    pcut_wake_ctrl #(.GUARD_CYC(G), .WEXP0(E0), .WEXP1(E1), .WEXP2(E2), .WEXP3(E3)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en_wr(cfg_en_wr),
        .cfg_wsel_wr(cfg_wsel_wr), .enter_req(enter_req), .wake_rtc(wake_rtc),
        .wake_ext(wake_ext), .wake_key(wake_key), .cfg_en(cfg_en),
        .cfg_wsel(cfg_wsel), .cfg_rejected(cfg_rejected), .pwr_en(pwr_en),
        .hot_rst_n(hot_rst_n), .pad_iso(pad_iso), .in_gate_on(in_gate_on),
        .boot_rom_force(boot_rom_force)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic e, input logic [1:0] s);
        cfg_we = 1'b1; cfg_en_wr = e; cfg_wsel_wr = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic enter();
        enter_req = 1'b1;
        @(negedge clk);
        enter_req = 1'b0;
    endtask

    task automatic arm(input logic [1:0] s);
        wr(1'b0, 2'b00);
        repeat (G) @(negedge clk);
        wr(1'b1, s);
    endtask

    // src: 0 rtc, 1..8 ext[src-1], 9 key bit kb
    task automatic drive(input int src, input int kb, input logic v);
        if (src == 0) wake_rtc = v;
        else if (src <= 8) wake_ext[src-1] = v;
        else wake_key[kb] = v;
    endtask

    function automatic int wlen(input int s);
        case (s)
            0: return 1 << E0;
            1: return 1 << E1;
            2: return 1 << E2;
            default: return 1 << E3;
        endcase
    endfunction

    task automatic cycle_one(input int s, input int src, input int kb);
        logic act;
        int cyc;
        act = (src == 8) ? 1'b0 : 1'b1;
        arm(2'(s));
        chk("R2 set accepted", cfg_en, 1);
        chk("R2 wsel loaded", cfg_wsel, s);
        drive(src, kb, act);          // park at active level while running
        @(negedge clk);
        enter();
        chk("R5 cut pwr_en", pwr_en, 0);
        chk("R5 cut iso/gate/rst", {pad_iso, in_gate_on, hot_rst_n, boot_rom_force}, 4'b1001);
        drive(src, kb, !act);         // wrong-direction edge
        @(negedge clk);
        chk("R6 wrong edge ignored", pwr_en, 0);
        drive(src, kb, act);          // wake edge
        @(negedge clk);
        chk("R7 power back", pwr_en, 1);
        chk("R7 reset held", hot_rst_n, 0);
        cyc = 0;
        while (!hot_rst_n && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R8 warm-up length", cyc, wlen(s));
        chk("R8 release iso", {pad_iso, in_gate_on}, 2'b01);
        chk("R9 boot kept after exit", boot_rom_force, 1);
        drive(src, kb, !act);         // back to idle level
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset cfg", {cfg_en, cfg_wsel, cfg_rejected}, 0);
        chk("R1 reset outputs", {pwr_en, hot_rst_n, pad_iso, in_gate_on, boot_rom_force}, 5'b11010);

        // R4: guard boundary
        wr(1'b0, 2'b00);
        repeat (G - 1) @(negedge clk);
        wr(1'b1, 2'b10);
        chk("R4 guarded set ignored", cfg_en, 0);
        chk("R4 rejected flag", cfg_rejected, 1);
        wr(1'b1, 2'b10);
        chk("R4 set after guard", cfg_en, 1);
        chk("R2 rejected cleared", cfg_rejected, 0);

        // R3: sticky while set, clear forces select to 00
        wr(1'b1, 2'b01);
        chk("R3 set while set keeps wsel", cfg_wsel, 2);
        wr(1'b0, 2'b11);
        chk("R3 clear", cfg_en, 0);
        chk("R3 clear forces wsel 00", cfg_wsel, 0);

        // R6: edges while running are ignored
        arm(2'b00);
        wake_rtc = 1'b1; wake_ext = 8'h7F; wake_key = 9'h1FF;
        @(negedge clk);
        wake_rtc = 1'b0; wake_ext = 8'h80; wake_key = '0;
        @(negedge clk);
        chk("R6 running edges ignored", {pwr_en, hot_rst_n, pad_iso}, 3'b110);
        enter();
        chk("R6 no stale wake after entry", pwr_en, 0);
        wake_rtc = 1'b1;
        @(negedge clk);
        wake_rtc = 1'b0;
        while (!hot_rst_n) @(negedge clk);

        // R10: no re-entry without clear and set
        enter();
        chk("R10 unarmed entry ignored", pwr_en, 1);
        wr(1'b1, 2'b01);
        enter();
        chk("R10 set while set no rearm", pwr_en, 1);
        wr(1'b0, 2'b00);
        @(negedge clk);
        chk("R9 boot override cleared", boot_rom_force, 0);

        // Sweep: every select x every wake line
        for (int s = 0; s < 4; s++)
            for (int src = 0; src < 10; src++)
                cycle_one(s, src, (s * 2 + src) % 9);
        // Every key bit
        for (int kb = 0; kb < 9; kb++) cycle_one(0, 9, kb);

        // R10: full clear/set re-arms
        arm(2'b01);
        enter();
        chk("R10 rearmed entry", pwr_en, 0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule